// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a fast host bus reach registers that live in a slow, always-on domain without the host ever addressing them directly. The host stages an access in three holding registers (an enable word, a target address and a data word), then writes the start bit of a control register. The bridge raises a request toward the slow side and holds it, with every qualifier frozen, until the slow side acknowledges.

While the request is outstanding the control register reads 1, so software polls it until it reads 0. For a read, the data holding register then contains the word returned by the target. For a write, only the byte lanes marked in the enable word are meant to change at the target. Host writes that arrive while the bridge is busy are dropped, so a poll-before-stage discipline cannot be broken by a late store.

Top module: `regbridge_top`

## Requirements
- R1: After reset the control, enable, address and data registers all read 0 and `s_req` is low.
- R2: Host offsets select registers by `h_ofs[3:2]`: 0x0 control, 0x4 enable (8 bits), 0x8 target address (`ADDR_W` bits, zero-extended on read), 0xC data. Reads are combinational and have no side effect.
- R3: A host write to control with bit 0 set while idle raises `s_req` and makes control read 1 after that clock edge; control bits other than bit 0 are ignored, and a control write with bit 0 clear starts nothing.
- R4: While `s_req` is high and `s_ack` is low, `s_req`, `s_addr`, `s_wdata`, `s_we` and `s_be` hold steady; `s_we` is enable bit 0 and `s_be` is enable bits 7:4 (lane n covers data bits 8n+7:8n).
- R5: `s_ack` sampled high with `s_req` ends the access: control still reads 1 in the acknowledge cycle and reads 0, with `s_req` low, in the following cycle. `s_ack` while idle has no effect.
- R6: An access whose enable bit 0 is 0 is a read: at completion the data register takes the value on `s_rdata`, whatever the lane bits say.
- R7: An access whose enable bit 0 is 1 is a write of the staged data word with the lane mask from enable bits 7:4; the data register keeps the staged word afterwards, and an enable value of 0xF1 writes the whole word.
- R8: While busy, host writes to enable, address and data are ignored and a second start does not launch another access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe, one per cycle |
| h_ofs | input | 4 | Host byte offset of the register |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Host read data for `h_ofs` |
| s_req | output | 1 | Slow-side request, high while an access is outstanding |
| s_we | output | 1 | Slow-side write qualifier |
| s_addr | output | ADDR_W | Slow-side target address |
| s_be | output | DATA_W/8 | Slow-side byte-lane write enables |
| s_wdata | output | DATA_W | Slow-side write data |
| s_ack | input | 1 | Slow-side acknowledge |
| s_rdata | input | DATA_W | Slow-side read data, valid with `s_ack` |

## Verification
The completion of an access and a host store into the data register can land on the same clock edge: the acknowledge cycle still counts as busy, so the store must be lost and the data register must show the target word (read) or the staged word (write). The bench provokes this by raising a data-register write in exactly the cycle where it observes `s_ack` high, on a fixed share of the sweep transactions, and judges it by reading the data register afterwards against the value computed from its own model memory. A second overlap, a start command issued while a long acknowledge delay is pending, is judged by counting acknowledges at the slow-side model.

// File: rtl/regbridge_pkg.sv
package regbridge_pkg;
   // Host register slots, selected by byte offset bits 3:2.
   typedef enum logic [1:0] {
      SLOT_CTRL = 2'd0,
      SLOT_EN   = 2'd1,
      SLOT_ADDR = 2'd2,
      SLOT_DATA = 2'd3
   } slot_e;

   localparam int START_BIT = 0;  // control: start / busy
   localparam int WFLAG_BIT = 0;  // enable: write qualifier
   localparam int LANE_LSB  = 4;  // enable: first byte-lane bit
endpackage

// File: rtl/regbridge_seq.sv
module regbridge_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic ack,
   output logic busy,
   output logic done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          busy <= 1'b0;
      else if (busy && ack) busy <= 1'b0;
      else if (go)          busy <= 1'b1;
   end

   assign done = busy && ack;

   // R5: an acknowledge seen while idle leaves the sequencer idle
   a_r5_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ack && !go) |=> !busy);
endmodule

// File: rtl/regbridge_stage.sv
module regbridge_stage
   import regbridge_pkg::*;
#(
   parameter  int ADDR_W = 16,
   parameter  int DATA_W = 32,
   localparam int NB     = DATA_W / 8,
   localparam int EN_W   = LANE_LSB + NB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  slot_e             slot,
   input  logic [DATA_W-1:0] wdata,
   input  logic              cap,
   input  logic [DATA_W-1:0] cap_data,
   output logic [EN_W-1:0]   en_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         addr_q <= '0;
      end else if (wr_ok) begin
         if (slot == SLOT_EN)   en_q   <= wdata[EN_W-1:0];
         if (slot == SLOT_ADDR) addr_q <= wdata[ADDR_W-1:0];
      end
   end

   // Data word kept per byte lane: a completing read overrides a host store.
   for (genvar b = 0; b < NB; b++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            lane_q <= '0;
         else if (cap)                          lane_q <= cap_data[8*b +: 8];
         else if (wr_ok && slot == SLOT_DATA)   lane_q <= wdata[8*b +: 8];
      end
      assign data_q[8*b +: 8] = lane_q;
   end
endmodule

// File: rtl/regbridge_top.sv
module regbridge_top
   import regbridge_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                h_wr,
   input  logic [3:0]          h_ofs,
   input  logic [DATA_W-1:0]   h_wdata,
   output logic [DATA_W-1:0]   h_rdata,
   output logic                s_req,
   output logic                s_we,
   output logic [ADDR_W-1:0]   s_addr,
   output logic [DATA_W/8-1:0] s_be,
   output logic [DATA_W-1:0]   s_wdata,
   input  logic                s_ack,
   input  logic [DATA_W-1:0]   s_rdata
);
   localparam int NB   = DATA_W / 8;
   localparam int EN_W = LANE_LSB + NB;

   if (DATA_W % 8 != 0 || DATA_W < 8 || DATA_W > 32) begin : g_bad_data_w
      $error("regbridge_top: DATA_W must be 8, 16, 24 or 32");
   end
   if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr_w
      $error("regbridge_top: ADDR_W must lie in 1..DATA_W");
   end
   if (EN_W > DATA_W) begin : g_bad_en_w
      $error("regbridge_top: enable word does not fit the data width");
   end

   slot_e             slot;
   logic              busy, done, go, wr_ok, cap;
   logic [EN_W-1:0]   en_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              unused_ofs;

   assign slot       = slot_e'(h_ofs[3:2]);
   assign unused_ofs = ^h_ofs[1:0];
   assign wr_ok      = h_wr && !busy;
   assign go         = wr_ok && slot == SLOT_CTRL && h_wdata[START_BIT];
   assign cap        = done && !en_q[WFLAG_BIT];

   regbridge_seq u_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (go),
      .ack  (s_ack),
      .busy (busy),
      .done (done)
   );

   regbridge_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ok   (wr_ok),
      .slot    (slot),
      .wdata   (h_wdata),
      .cap     (cap),
      .cap_data(s_rdata),
      .en_q    (en_q),
      .addr_q  (addr_q),
      .data_q  (data_q)
   );

   assign s_req   = busy;
   assign s_we    = en_q[WFLAG_BIT];
   assign s_be    = en_q[LANE_LSB +: NB];
   assign s_addr  = addr_q;
   assign s_wdata = data_q;

   always_comb begin
      unique case (slot)
         SLOT_CTRL: h_rdata = {{(DATA_W-1){1'b0}}, busy};
         SLOT_EN:   h_rdata = DATA_W'(en_q);
         SLOT_ADDR: h_rdata = DATA_W'(addr_q);
         default:   h_rdata = data_q;
      endcase
   end

   // R3: an idle start command raises the request on the next edge
   a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
      (h_wr && h_ofs[3:2] == 2'd0 && h_wdata[0] && !s_req) |=> s_req);

   // R4: request and its qualifiers frozen until acknowledged
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (s_req && !s_ack) |=> (s_req && $stable(s_addr) && $stable(s_wdata)
                             && $stable(s_be) && $stable(s_we)));

   // R5: request drops in the cycle after the acknowledge
   a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
      (s_req && s_ack) |=> !s_req);

   // R6: a completing read lands the returned word in the data register
   a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (s_req && s_ack && !s_we) |=> (h_ofs[3:2] != 2'd3 || h_rdata == $past(s_rdata)));

   // R8: staged state untouched by host stores while busy
   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      s_req |=> ($stable(en_q) && $stable(addr_q)));
endmodule

// File: tb/regbridge_top_tb.sv
module regbridge_top_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        h_wr;
   logic [3:0]  h_ofs;
   logic [31:0] h_wdata, h_rdata;
   logic        s_req, s_we, s_ack;
   logic [15:0] s_addr;
   logic [3:0]  s_be;
   logic [31:0] s_wdata, s_rdata;

   int errors = 0, checks = 0;
   bit finished = 1'b0;

   logic [31:0] mem [16];
   int          force_dly = -1, cur_dly = 0, wait_cnt = 0, ack_cnt = 0;
   logic [7:0]  lfsr = 8'h5B;

   always #10 clk = ~clk;

   regbridge_top #(.ADDR_W(16), .DATA_W(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_ofs(h_ofs), .h_wdata(h_wdata),
      .h_rdata(h_rdata), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
      .s_be(s_be), .s_wdata(s_wdata), .s_ack(s_ack), .s_rdata(s_rdata));

   // Slow-side register array with a variable acknowledge delay.
   always @(negedge clk) begin
      if (!rst_n) begin
         s_ack = 1'b0; wait_cnt = 0;
      end else if (s_ack) begin
         s_ack = 1'b0;
      end else if (s_req) begin
         if (wait_cnt >= cur_dly) begin
            s_rdata = mem[s_addr[3:0]];
            if (s_we)
               for (int b = 0; b < 4; b++)
                  if (s_be[b]) mem[s_addr[3:0]][8*b +: 8] = s_wdata[8*b +: 8];
            s_ack = 1'b1; ack_cnt++; wait_cnt = 0;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cur_dly = (force_dly >= 0) ? force_dly : int'(lfsr[1:0]);
         end else wait_cnt++;
      end
   end

   function automatic logic [31:0] pat(int a);
      return 32'h1357_9BDF ^ (a * 32'h0102_0408);
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic hwrite(logic [3:0] ofs, logic [31:0] v);
      @(negedge clk); h_wr = 1'b1; h_ofs = ofs; h_wdata = v;
      @(negedge clk); h_wr = 1'b0;
   endtask

   task automatic peek(logic [3:0] ofs, output logic [31:0] v);
      h_ofs = ofs; #1; v = h_rdata;
   endtask

   // Waits for the acknowledge and judges busy timing; optionally stores
   // into the data register in the acknowledge cycle.
   task automatic finish_xact(bit collide);
      logic [31:0] v;
      int n = 0;
      #1;
      while (!s_ack && n < 200) begin @(negedge clk); #1; n++; end
      chk("R5 acknowledge arrives", 32'(n < 200), 32'd1);
      peek(4'h0, v); chk("R5 busy in ack cycle", v, 32'd1);
      if (collide) begin h_wr = 1'b1; h_ofs = 4'hC; h_wdata = 32'hDEAD_BEEF; end
      @(negedge clk); h_wr = 1'b0; #1;
      peek(4'h0, v); chk("R5 idle after ack", v, 32'd0);
      chk("R5 request low after ack", 32'(s_req), 32'd0);
   endtask

   task automatic xact(logic [7:0] en, logic [31:0] addr, logic [31:0] d, bit collide);
      logic [31:0] v;
      hwrite(4'h4, 32'(en)); hwrite(4'h8, addr); hwrite(4'hC, d); hwrite(4'h0, 32'd1);
      peek(4'h0, v); chk("R3 busy after start", v, 32'd1);
      finish_xact(collide);
   endtask

   initial begin
      logic [31:0] v, e, base, nw;
      int a0;
      rst_n = 1'b0; h_wr = 1'b0; h_ofs = 4'h0; h_wdata = '0;
      s_ack = 1'b0; s_rdata = '0;
      for (int i = 0; i < 16; i++) mem[i] = 32'hFFFF_0000 | 32'(i);
      repeat (3) @(negedge clk);
      for (int o = 0; o < 4; o++) begin
         peek(4'(o * 4), v); chk("R1 reset value", v, 32'd0);
      end
      chk("R1 request low in reset", 32'(s_req), 32'd0);
      rst_n = 1'b1;

      // R2: staging register read-back and widths
      hwrite(4'h4, 32'hFFFF_FFF1); peek(4'h4, v); chk("R2 enable read-back", v, 32'h0000_00F1);
      hwrite(4'h8, 32'hFFFF_1234); peek(4'h8, v); chk("R2 address read-back", v, 32'h0000_1234);
      hwrite(4'hD, 32'hCAFE_F00D); peek(4'hC, v); chk("R2 data read-back", v, 32'hCAFE_F00D);

      // R3: start bit clear starts nothing; extra control bits ignored
      hwrite(4'h0, 32'hFFFF_FFFE); peek(4'h0, v); chk("R3 no start on bit0=0", v, 32'd0);
      chk("R3 request stays low", 32'(s_req), 32'd0);
      hwrite(4'h0, 32'h0000_0003);
      peek(4'h0, v); chk("R3 start with extra bits", v, 32'd1);
      chk("R4 address qualifier", 32'(s_addr), 32'h1234);
      chk("R4 lane qualifier", 32'(s_be), 32'hF);
      chk("R4 write qualifier", 32'(s_we), 32'd1);
      chk("R4 data qualifier", s_wdata, 32'hCAFE_F00D);
      finish_xact(1'b0);
      chk("R7 full write reaches target", mem[4], 32'hCAFE_F00D);

      // R7 / R6: address sweep of full writes then reads, with collisions
      for (int a = 0; a < 16; a++) begin
         xact(8'hF1, 32'(a), pat(a), (a % 3) == 0);
         peek(4'hC, v); chk("R7 data register keeps staged word", v, pat(a));
      end
      for (int a = 0; a < 16; a++) begin
         xact(8'h00, 32'(a), 32'h0, (a % 4) == 1);
         peek(4'hC, v); chk("R6 read returns target word", v, pat(a));
      end

      // R7: every lane mask on one word
      for (int be = 0; be < 16; be++) begin
         base = 32'h1122_3344; nw = 32'hA0B0_C0D0 + 32'(be);
         xact(8'hF1, 32'd7, base, 1'b0);
         xact({4'(be), 4'h1}, 32'd7, nw, 1'b0);
         xact(8'h00, 32'd7, 32'h0, 1'b0);
         for (int b = 0; b < 4; b++) e[8*b +: 8] = be[b] ? nw[8*b +: 8] : base[8*b +: 8];
         peek(4'hC, v); chk("R7 lane-masked write", v, e);
      end

      // R6: lanes set without the write flag still read
      xact(8'hF0, 32'd7, 32'hFFFF_FFFF, 1'b0);
      peek(4'hC, v); chk("R6 lanes without write flag read", v, 32'hA0B0_C0DF);
      chk("R6 target untouched", mem[7], 32'hA0B0_C0DF);

      // R8: stores and restart while a long access is pending
      force_dly = 12; cur_dly = 12;
      hwrite(4'h4, 32'h0); hwrite(4'h8, 32'd3); hwrite(4'h0, 32'd1);
      a0 = ack_cnt;
      hwrite(4'h4, 32'hF1); hwrite(4'h8, 32'd9); hwrite(4'hC, 32'h1); hwrite(4'h0, 32'd1);
      chk("R4 address held while busy", 32'(s_addr), 32'd3);
      chk("R4 write flag held while busy", 32'(s_we), 32'd0);
      finish_xact(1'b0);
      force_dly = -1; cur_dly = 0;
      peek(4'h4, v); chk("R8 enable store ignored", v, 32'h0);
      peek(4'h8, v); chk("R8 address store ignored", v, 32'd3);
      peek(4'hC, v); chk("R8 data holds read result", v, pat(3));
      repeat (3) @(negedge clk); #1;
      chk("R8 single access only", 32'(ack_cnt - a0), 32'd1);
      chk("R8 no second request", 32'(s_req), 32'd0);
      chk("R8 target untouched", mem[9], pat(9));

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog R5 got=hung exp=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule